// File: doc/BRIEF.md
# Dual-Ratio Shift-Register Clock Divider

This block divides its input clock by seven or by nine, the ratio chosen by a single standard-select pin (low selects the NTSC ratio, high selects the PAL ratio). It keeps no binary count. A four-bit shift register runs instead, and its serial input bit is a small combinational function of a few register taps. The taps used depend on the selected ratio, so the same four flip-flops walk a seven-state loop or a nine-state loop.

Two strobes are decoded from the register contents. The phase-0 strobe marks the start of each divide period. The phase-3 strobe follows it three clocks later. Each strobe is high for one clock per period, so downstream logic can use them directly as clock enables. The raw register is also brought out for debug.

The pins carry no data stream: every input and output is a plain control or status level, and there is no handshake and no back-pressure. Reset is active low and synchronous. The select pin may be changed at any time and takes effect on the next rising edge.

Top module: `dual_ratio_divider`

## Requirements
- R1: While `rst_n` is low, `phase0_o` and `phase3_o` are low at once, and every rising edge with `rst_n` low clears `taps_o` to 4'b0000.
- R2: At the first rising edge with `rst_n` high after reset, `taps_o` becomes 4'b0001 and `phase0_o` goes high.
- R3: With `pal_sel` low, `phase0_o` is high once every 7 clocks.
- R4: With `pal_sel` high, `phase0_o` is high once every 9 clocks.
- R5: Each strobe is high for exactly one clock at a time.
- R6: `phase3_o` is high exactly 3 clocks after each `phase0_o` pulse and never in the same clock.
- R7: On each edge out of reset, `taps_o[3:1]` takes the old `taps_o[2:0]` and bit 0 takes the new serial bit. That bit is NOR(h, m, taps_o[0]) OR (h XOR m), where h/m are taps_o[2]/taps_o[1] for the 7-clock ratio and taps_o[3]/taps_o[2] for the 9-clock ratio. After reset, the first four states are 0001, 0010, 0101, 1011 in both ratios.
- R8: After `pal_sel` changes, `phase0_o` pulses within 16 clocks. From then on the period is the one for the new ratio, and no register state locks up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock to be divided |
| rst_n | input | 1 | Synchronous reset, active low |
| pal_sel | input | 1 | Ratio select: 0 divides by 7, 1 divides by 9 |
| phase0_o | output | 1 | One-clock strobe at the start of each period |
| phase3_o | output | 1 | One-clock strobe three clocks after phase0_o |
| taps_o | output | 4 | Shift-register contents, bit 0 newest |

## Verification
The table drives both ratios from reset with different reset hold lengths. This separates the 7-clock loop from the 9-clock loop, and it shows that the first four states after release are shared. The directed tests drop reset in the middle of a phase-0 pulse, which shows that the outputs fall at once and that the register clears on the next edge. They also switch the ratio in the middle of a period in both directions, which tells a clean resettle apart from a stuck state or a period that keeps the old ratio.

// File: rtl/drd_pkg.sv
package drd_pkg;
  localparam int STATE_W    = 4;
  localparam int NTSC_DIV   = 2 * STATE_W - 1;
  localparam int PAL_DIV    = 2 * STATE_W + 1;
  localparam int PHASE3_LAG = 3;
  localparam int SETTLE_MAX = 16;

  typedef logic [STATE_W-1:0] taps_t;

  typedef enum logic {
    STD_NTSC = 1'b0,
    STD_PAL  = 1'b1
  } std_e;

  // Serial bit entering stage 0 for the given state and ratio.
  function automatic logic next_bit(input taps_t t, input logic pal);
    logic hi;
    logic mid;
    hi  = pal ? t[STATE_W-1] : t[STATE_W-2];
    mid = pal ? t[STATE_W-2] : t[STATE_W-3];
    return ~(hi | mid | t[0]) | (hi ^ mid);
  endfunction

  // Register contents after n shifts from state t.
  function automatic taps_t advance(input taps_t t, input logic pal, input int n);
    taps_t s;
    s = t;
    for (int i = 0; i < n; i++) s = {s[STATE_W-2:0], next_bit(s, pal)};
    return s;
  endfunction
endpackage

// File: rtl/drd_feedback.sv
module drd_feedback
  import drd_pkg::*;
(
  input  taps_t state_i,
  input  logic  pal_i,
  output logic  serial_o
);
  always_comb serial_o = next_bit(state_i, pal_i);
endmodule

// File: rtl/drd_shift_chain.sv
module drd_shift_chain
  import drd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  serial_i,
  output taps_t state_o
);
  for (genvar i = 0; i < STATE_W; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) state_o[i] <= 1'b0;
        else        state_o[i] <= serial_i;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n) state_o[i] <= 1'b0;
        else        state_o[i] <= state_o[i-1];
      end
    end
  end
endmodule

// File: rtl/drd_phase_decode.sv
module drd_phase_decode
  import drd_pkg::*;
(
  input  logic  rst_n,
  input  logic  pal_i,
  input  taps_t state_i,
  output logic  phase0_o,
  output logic  phase3_o
);
  localparam taps_t P0_CODE   = advance('0, STD_NTSC, 1);
  localparam taps_t P3_CODE   = advance('0, STD_NTSC, 1 + PHASE3_LAG);
  localparam taps_t MASK_NTSC = {1'b0, {(STATE_W-1){1'b1}}};

  taps_t mask;

  always_comb begin
    mask     = pal_i ? '1 : MASK_NTSC;
    phase0_o = rst_n && (((state_i ^ P0_CODE) & mask) == '0);
    phase3_o = rst_n && (((state_i ^ P3_CODE) & mask) == '0);
  end
endmodule

// File: rtl/dual_ratio_divider.sv
module dual_ratio_divider
  import drd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pal_sel,
  output logic               phase0_o,
  output logic               phase3_o,
  output logic [STATE_W-1:0] taps_o
);
  localparam int CNT_W = $clog2(SETTLE_MAX + PAL_DIV) + 1;

  taps_t state;
  logic  serial;

  drd_feedback u_feedback (
    .state_i  (state),
    .pal_i    (pal_sel),
    .serial_o (serial)
  );

  drd_shift_chain u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .serial_i (serial),
    .state_o  (state)
  );

  drd_phase_decode u_decode (
    .rst_n    (rst_n),
    .pal_i    (pal_sel),
    .state_i  (state),
    .phase0_o (phase0_o),
    .phase3_o (phase3_o)
  );

  assign taps_o = state;

  // Checker support state.
  logic                  pal_q;
  logic                  armed;
  logic [CNT_W-1:0]      gap_cnt;
  logic [PHASE3_LAG-1:0] p0_hist;
  logic                  sel_changed;

  assign sel_changed = (pal_sel != pal_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pal_q   <= pal_sel;
      armed   <= 1'b0;
      gap_cnt <= '0;
      p0_hist <= '0;
    end else begin
      pal_q   <= pal_sel;
      p0_hist <= {p0_hist[PHASE3_LAG-2:0], phase0_o};
      if (sel_changed) begin
        armed   <= 1'b0;
        gap_cnt <= '0;
      end else if (phase0_o) begin
        armed   <= 1'b1;
        gap_cnt <= '0;
      end else if (gap_cnt != '1) begin
        gap_cnt <= gap_cnt + 1'b1;
      end
    end
  end

  // R1
  always_comb begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!phase0_o && !phase3_o);
    end
  end

  // R3 R4
  period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase0_o && armed) |-> (int'(gap_cnt) == (pal_q ? PAL_DIV : NTSC_DIV) - 1));

  // R5
  p0_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase0_o |=> !phase0_o);

  // R5
  p3_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase3_o |=> !phase3_o);

  // R6
  p3_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p0_hist[PHASE3_LAG-1] |-> phase3_o);

  // R6
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({phase0_o, phase3_o}));

  // R7
  shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (taps_o[STATE_W-1:1] == $past(taps_o[STATE_W-2:0])));

  // R8
  settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(gap_cnt) < SETTLE_MAX);
endmodule

// File: tb/dual_ratio_divider_bench.sv
`timescale 1ns/1ps
module dual_ratio_divider_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pal_sel = 1'b0;
  logic       phase0_o;
  logic       phase3_o;
  logic [3:0] taps_o;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  always #2.5 clk = ~clk;

  dual_ratio_divider u_dual_ratio_divider (
    .clk      (clk),
    .rst_n    (rst_n),
    .pal_sel  (pal_sel),
    .phase0_o (phase0_o),
    .phase3_o (phase3_o),
    .taps_o   (taps_o)
  );

  // {pal, reset hold cycles, run cycles}
  localparam logic [15:0] VEC [5] = '{
    {1'b0, 7'd2, 8'd40},
    {1'b1, 7'd1, 8'd45},
    {1'b0, 7'd5, 8'd22},
    {1'b1, 7'd3, 8'd30},
    {1'b1, 7'd1, 8'd19}
  };

  localparam logic [3:0] START_SEQ [4] = '{4'b0001, 4'b0010, 4'b0101, 4'b1011};

  task automatic chk(input logic [3:0] got, input logic [3:0] exp, input string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", what, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Switch ratio mid-period and measure the resettle and the new cadence.
  task automatic switch_and_measure(input logic to_pal);
    int n;
    int g;
    int p3_at;
    pal_sel = to_pal;
    n = 0;
    do begin
      tick();
      n++;
    end while (!phase0_o && n < 40);
    chk({3'b0, n <= 16}, 4'b1, to_pal ? "R8 settle into 9-clock loop" : "R8 settle into 7-clock loop");
    g = 0;
    p3_at = -1;
    do begin
      tick();
      g++;
      if (phase3_o) p3_at = g;
    end while (!phase0_o && g < 40);
    chk(4'(g), to_pal ? 4'd9 : 4'd7, to_pal ? "R8 R4 period after switch" : "R8 R3 period after switch");
    chk(4'(p3_at), 4'd3, "R6 phase3 lag after switch");
  endtask

  initial begin
    for (int v = 0; v < 5; v++) begin
      int hold;
      int run;
      int div;
      pal_sel = VEC[v][15];
      hold    = int'(VEC[v][14:8]);
      run     = int'(VEC[v][7:0]);
      div     = pal_sel ? 9 : 7;
      rst_n   = 1'b0;
      for (int h = 0; h < hold; h++) begin
        tick();
        chk(taps_o, 4'b0000, "R1 taps cleared in reset");
        chk({2'b0, phase0_o, phase3_o}, 4'b0000, "R1 strobes low in reset");
      end
      rst_n = 1'b1;
      for (int k = 0; k < run; k++) begin
        int ph;
        tick();
        ph = k % div;
        if (k == 0) chk({3'b0, phase0_o}, 4'b1, "R2 phase0 on first edge");
        chk({3'b0, phase0_o}, {3'b0, ph == 0}, pal_sel ? "R4 R5 phase0 cadence" : "R3 R5 phase0 cadence");
        chk({3'b0, phase3_o}, {3'b0, ph == 3}, "R6 R5 phase3 position");
        if (k < 4) chk(taps_o, START_SEQ[k], "R7 state sequence after reset");
      end
    end

    // Reset dropped during a phase-0 pulse.
    for (int i = 0; i < 12 && !phase0_o; i++) tick();
    chk({3'b0, phase0_o}, 4'b1, "R4 phase0 present before reset");
    rst_n = 1'b0;
    #1;
    chk({2'b0, phase0_o, phase3_o}, 4'b0000, "R1 strobes drop with reset");
    tick();
    chk(taps_o, 4'b0000, "R1 taps cleared mid-run");
    rst_n = 1'b1;
    tick();
    chk(taps_o, 4'b0001, "R2 restart state");
    chk({3'b0, phase0_o}, 4'b1, "R2 restart phase0");

    // 7-clock run, then switch to 9, then back to 7 mid-period.
    pal_sel = 1'b0;
    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) tick();
    switch_and_measure(1'b1);
    for (int i = 0; i < 6; i++) tick();
    switch_and_measure(1'b0);
    tick();
    tick();
    switch_and_measure(1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule